// File: doc/BRIEF.md
# Hit Timestamp and Serial Record Readout

This block sits behind sixteen channel discriminators in a photodetector front end. It keeps a free-running coarse time counter, advanced by a slow time-base strobe. The counter is 24 bits wide, and one strobe is expected every 100 ns. When a channel trigger rises, the block stores the channel index and the current coarse count in a small pending-hit queue. An OR of all triggers is brought out for use by external logic.

A readout engine drains the queue one hit at a time. For each hit it asks an external converter for two 12-bit codes: the fine time, which interpolates within one coarse step, and the charge. The converter delivers them through a ready/valid handshake. The engine then joins the four fields into one 52-bit record. It sends the record most significant bit first on a single data wire, one bit per clock, with a frame strobe marking the record.

When several channels rise in the same clock, they enter the queue together, lowest index first. Hits that find no room are lost, and a sticky flag records the loss.

Top module: `hit_serializer`

## Requirements
- R1: `trig_or_o` equals the OR of all sixteen `trig_i` bits in the same cycle, with no register in the path.
- R2: A hit is a rising edge of a trigger bit, meaning high in this cycle and low in the previous one. A trigger held high for many cycles yields exactly one record.
- R3: The coarse count resets to 0 and advances by one, modulo 2^24, on every clock where `tick_i` is high. It holds otherwise. A hit's timestamp is the count in force at the clock edge that samples the trigger's rising edge, which equals the number of ticks sampled on earlier edges since reset.
- R4: Triggers that rise in the same cycle give records in ascending channel order, all with the same timestamp. Records leave in the order the hits entered the queue.
- R5: The queue holds 8 hits. When a cycle's new hits exceed the free room, the lowest-numbered rising channels fill the room and the rest are dropped and never sent. No hit is dropped while room remains.
- R6: `overflow_o` goes high on the edge after a hit is dropped. It stays high until reset.
- R7: When the engine is idle and the queue is not empty, it takes the oldest hit on one edge and raises `conv_ready_o` from the next cycle on. `conv_ready_o` stays high until `conv_valid_i` is seen with it. On that edge `fine_i` and `charge_i` are captured, `conv_ready_o` falls, and the frame starts in the next cycle.
- R8: A record is 52 bits wide. Bits [51:48] hold the channel, [47:24] the timestamp, [23:12] the fine code and [11:0] the charge code. Bit 51 goes out first.
- R9: `ser_frame_o` is high for exactly 52 consecutive cycles per record, with one record bit on `ser_data_o` in each of those cycles. Outside a frame `ser_data_o` is 0. Two frames are always separated by at least two low cycles.
- R10: While `rst_n` is low at a clock edge, the queue empties, the counter clears, and `conv_ready_o`, `ser_frame_o`, `ser_data_o` and `overflow_o` are 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System and bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_i | input | 16 | Channel discriminator outputs, synchronous to clk |
| tick_i | input | 1 | Coarse time-base strobe, one clock wide |
| conv_valid_i | input | 1 | Converter codes are valid |
| fine_i | input | 12 | Fine-time code from the converter |
| charge_i | input | 12 | Charge code from the converter |
| trig_or_o | output | 1 | OR of all trigger inputs |
| conv_ready_o | output | 1 | Engine is waiting for converter codes |
| ser_data_o | output | 1 | Serial record data, MSB first |
| ser_frame_o | output | 1 | High while a record bit is on the data line |
| overflow_o | output | 1 | Sticky flag for dropped hits |

## Verification
`trig_or_o` is due in the same cycle as the trigger. The record is queued on the edge that samples the rising trigger. With an idle engine, `conv_ready_o` is due after the second edge, and the bench checks it low after the first edge and high after the second. The frame is due one cycle after the handshake edge, and each of its 52 bits is read 1 ns after a falling edge, as are the end of the frame and the overflow flag one edge after a drop. The bench builds expected records from its own tick count and edge history, and compares them in arrival order.

// File: rtl/hs_pkg.sv
// Shared constants and the readout engine state type for the hit serializer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package hs_pkg;

    localparam int HS_CHANNELS    = 16;
    localparam int HS_STAMP_W     = 24;
    localparam int HS_CODE_W      = 12;
    localparam int HS_QUEUE_DEPTH = 8;

    typedef enum logic [1:0] {
        SR_IDLE = 2'd0,
        SR_WAIT = 2'd1,
        SR_SEND = 2'd2
    } sr_state_e;

endpackage

// File: rtl/hs_coarse_timer.sv
// Coarse time counter: advances by one on every clock with the time-base
// strobe high and wraps to zero past its top value without stalling.
// Assumes: tick_i is synchronous to clk; the reset is synchronous, active low.
module hs_coarse_timer #(
    parameter int STAMP_W = hs_pkg::HS_STAMP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    output logic [STAMP_W-1:0] stamp_o
);

    logic [STAMP_W-1:0] count_q;

    // Count strobes; natural binary overflow gives the wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign stamp_o = count_q;

    // R3: a strobe moves the count by exactly one, including the wrap
    p_coarse_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> stamp_o == $past(stamp_o) + 1'b1);

    // R3: without a strobe the count holds
    p_coarse_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(stamp_o));

endmodule

// File: rtl/hs_hit_queue.sv
// Pending-hit queue: detects trigger rising edges and writes every new hit
// of a cycle at once, lowest channel first, into a circular store. Hits
// that do not fit the free room are dropped and set a sticky flag.
// Assumes: DEPTH is a power of two; pop_i is only raised when not empty.
module hs_hit_queue #(
    parameter  int CHAN_N = hs_pkg::HS_CHANNELS,
    parameter  int STAMP_W = hs_pkg::HS_STAMP_W,
    parameter  int DEPTH = hs_pkg::HS_QUEUE_DEPTH,
    localparam int CHAN_W = $clog2(CHAN_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CHAN_N-1:0]  trig_i,
    input  logic [STAMP_W-1:0] stamp_i,
    input  logic               pop_i,
    output logic               empty_o,
    output logic [CHAN_W-1:0]  head_chan_o,
    output logic [STAMP_W-1:0] head_stamp_o,
    output logic               overflow_o
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int ENT_W = CHAN_W + STAMP_W;

    logic [CHAN_N-1:0] trig_q;
    logic [CHAN_N-1:0] rise_w;
    logic [CHAN_N-1:0] take_w;
    logic [PTR_W-1:0]  slot_w [CHAN_N];
    logic [LVL_W-1:0]  n_take_w;
    logic              drop_w;
    logic [ENT_W-1:0]  store_q [DEPTH];
    logic [PTR_W-1:0]  wr_q;
    logic [PTR_W-1:0]  rd_q;
    logic [LVL_W-1:0]  level_q;
    logic              ovf_q;

    assign rise_w = trig_i & ~trig_q;

    // Keep last cycle's trigger levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0;
        end else begin
            trig_q <= trig_i;
        end
    end

    // Rank the rising channels and give each one a slot while room lasts
    always_comb begin
        int run;
        int room;
        run    = 0;
        room   = DEPTH - int'(level_q);
        take_w = '0;
        drop_w = 1'b0;
        for (int c = 0; c < CHAN_N; c++) begin
            slot_w[c] = wr_q + PTR_W'(run);
            if (rise_w[c]) begin
                if (run < room) begin
                    take_w[c] = 1'b1;
                end else begin
                    drop_w = 1'b1;
                end
                run++;
            end
        end
        n_take_w = (run < room) ? LVL_W'(run) : LVL_W'(room);
    end

    // Write every accepted hit of this cycle into its slot
    always_ff @(posedge clk) begin
        for (int c = 0; c < CHAN_N; c++) begin
            if (take_w[c]) begin
                store_q[slot_w[c]] <= {CHAN_W'(c), stamp_i};
            end
        end
    end

    // Move the pointers and the fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= '0;
            rd_q    <= '0;
            level_q <= '0;
        end else begin
            wr_q    <= wr_q + PTR_W'(n_take_w);
            rd_q    <= rd_q + PTR_W'(pop_i);
            level_q <= level_q + n_take_w - LVL_W'(pop_i);
        end
    end

    // Remember any loss until reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (drop_w) begin
            ovf_q <= 1'b1;
        end
    end

    assign empty_o      = (level_q == '0);
    assign head_chan_o  = store_q[rd_q][ENT_W-1 -: CHAN_W];
    assign head_stamp_o = store_q[rd_q][STAMP_W-1:0];
    assign overflow_o   = ovf_q;

    // R5: the fill level never passes the depth
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= LVL_W'(DEPTH));

    // R5: a drop without a pop leaves the store completely full
    p_drop_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drop_w && !pop_i |=> level_q == LVL_W'(DEPTH));

    // R6: the loss flag never falls outside reset
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    // R7: the engine takes a hit only when one is stored
    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> level_q != '0);

endmodule

// File: rtl/hs_record_shifter.sv
// Readout engine: takes the oldest hit, waits for the converter's fine-time
// and charge codes, then shifts the joined record out MSB first, one bit
// per clock, with a frame strobe.
// Assumes: the converter holds its codes steady while conv_valid_i is high.
module hs_record_shifter
    import hs_pkg::*;
#(
    parameter  int CHAN_W  = 4,
    parameter  int STAMP_W = hs_pkg::HS_STAMP_W,
    parameter  int CODE_W  = hs_pkg::HS_CODE_W,
    localparam int REC_W   = CHAN_W + STAMP_W + 2 * CODE_W,
    localparam int CNT_W   = $clog2(REC_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               empty_i,
    input  logic [CHAN_W-1:0]  head_chan_i,
    input  logic [STAMP_W-1:0] head_stamp_i,
    input  logic               conv_valid_i,
    input  logic [CODE_W-1:0]  fine_i,
    input  logic [CODE_W-1:0]  charge_i,
    output logic               pop_o,
    output logic               conv_ready_o,
    output logic               ser_data_o,
    output logic               ser_frame_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(REC_W - 1);

    sr_state_e          state_q;
    logic [CHAN_W-1:0]  chan_q;
    logic [STAMP_W-1:0] stamp_q;
    logic [REC_W-1:0]   shreg_q;
    logic [CNT_W-1:0]   bit_q;
    logic               accept_w;

    assign pop_o    = (state_q == SR_IDLE) && !empty_i;
    assign accept_w = (state_q == SR_WAIT) && conv_valid_i;

    // Step the engine through take, wait and send
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SR_IDLE;
        end else begin
            unique case (state_q)
                SR_IDLE: if (pop_o) state_q <= SR_WAIT;
                SR_WAIT: if (conv_valid_i) state_q <= SR_SEND;
                SR_SEND: if (bit_q == LAST_BIT) state_q <= SR_IDLE;
                default: state_q <= SR_IDLE;
            endcase
        end
    end

    // Hold the taken hit while the converter works
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q  <= '0;
            stamp_q <= '0;
        end else if (pop_o) begin
            chan_q  <= head_chan_i;
            stamp_q <= head_stamp_i;
        end
    end

    // Load the joined record, then shift it left once per bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bit_q   <= '0;
        end else if (accept_w) begin
            shreg_q <= {chan_q, stamp_q, fine_i, charge_i};
            bit_q   <= '0;
        end else if (state_q == SR_SEND) begin
            shreg_q <= shreg_q << 1;
            bit_q   <= bit_q + 1'b1;
        end
    end

    assign conv_ready_o = (state_q == SR_WAIT);
    assign ser_frame_o  = (state_q == SR_SEND);
    assign ser_data_o   = ser_frame_o & shreg_q[REC_W-1];

    // R7: the request stays up until codes arrive
    p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_ready_o && !conv_valid_i |=> conv_ready_o);

    // R7: a completed handshake starts the frame in the next cycle
    p_accept_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_ready_o && conv_valid_i |=> ser_frame_o && !conv_ready_o);

    // R8: the first bit on the line is the channel's top bit
    p_first_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_ready_o && conv_valid_i |=> ser_data_o == $past(chan_q[CHAN_W-1]));

    // R9: the frame does not break before its last bit
    p_frame_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ser_frame_o && bit_q != LAST_BIT |=> ser_frame_o);

    // R9: the frame ends right after its last bit
    p_frame_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ser_frame_o && bit_q == LAST_BIT |=> !ser_frame_o);

endmodule

// File: rtl/hit_serializer.sv
// Hit timestamp and serial readout top: joins the coarse timer, the
// pending-hit queue and the readout engine, and drives the trigger OR.
// Assumes: triggers and the time-base strobe are synchronous to clk.
module hit_serializer #(
    parameter int CHAN_N  = hs_pkg::HS_CHANNELS,
    parameter int STAMP_W = hs_pkg::HS_STAMP_W,
    parameter int CODE_W  = hs_pkg::HS_CODE_W,
    parameter int DEPTH   = hs_pkg::HS_QUEUE_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAN_N-1:0] trig_i,
    input  logic              tick_i,
    input  logic              conv_valid_i,
    input  logic [CODE_W-1:0] fine_i,
    input  logic [CODE_W-1:0] charge_i,
    output logic              trig_or_o,
    output logic              conv_ready_o,
    output logic              ser_data_o,
    output logic              ser_frame_o,
    output logic              overflow_o
);

    localparam int CHAN_W = $clog2(CHAN_N);

    logic [STAMP_W-1:0] stamp_w;
    logic               empty_w;
    logic               pop_w;
    logic [CHAN_W-1:0]  head_chan_w;
    logic [STAMP_W-1:0] head_stamp_w;

    assign trig_or_o = |trig_i;

    hs_coarse_timer #(
        .STAMP_W (STAMP_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .stamp_o (stamp_w)
    );

    hs_hit_queue #(
        .CHAN_N  (CHAN_N),
        .STAMP_W (STAMP_W),
        .DEPTH   (DEPTH)
    ) u_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig_i),
        .stamp_i      (stamp_w),
        .pop_i        (pop_w),
        .empty_o      (empty_w),
        .head_chan_o  (head_chan_w),
        .head_stamp_o (head_stamp_w),
        .overflow_o   (overflow_o)
    );

    hs_record_shifter #(
        .CHAN_W  (CHAN_W),
        .STAMP_W (STAMP_W),
        .CODE_W  (CODE_W)
    ) u_shifter (
        .clk          (clk),
        .rst_n        (rst_n),
        .empty_i      (empty_w),
        .head_chan_i  (head_chan_w),
        .head_stamp_i (head_stamp_w),
        .conv_valid_i (conv_valid_i),
        .fine_i       (fine_i),
        .charge_i     (charge_i),
        .pop_o        (pop_w),
        .conv_ready_o (conv_ready_o),
        .ser_data_o   (ser_data_o),
        .ser_frame_o  (ser_frame_o)
    );

endmodule

// File: tb/hit_serializer_test.sv
// Bench for hit_serializer: directed corner cases, then random triggers,
// ticks and converter latency, checked against a model kept in the bench.
module hit_serializer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] trig = '0;
    logic        tick = 1'b0;
    logic        conv_valid;
    logic [11:0] fine;
    logic [11:0] charge;
    logic        trig_or, conv_ready, ser_data, ser_frame, overflow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0]  exp_chan [4096];
    logic [23:0] exp_ts   [4096];
    int          exp_wr = 0;
    int          rx_idx = 0;
    int          conv_idx = 0;
    logic [15:0] trig_prev = '0;
    logic [23:0] tick_cnt = '0;
    bit          resp_en = 1'b0;
    bit          resp_rand = 1'b0;

    hit_serializer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig),
        .tick_i       (tick),
        .conv_valid_i (conv_valid),
        .fine_i       (fine),
        .charge_i     (charge),
        .trig_or_o    (trig_or),
        .conv_ready_o (conv_ready),
        .ser_data_o   (ser_data),
        .ser_frame_o  (ser_frame),
        .overflow_o   (overflow)
    );

    always #4 clk = ~clk;

    function automatic logic [11:0] fine_of(input int i);
        return 12'((i * 37 + 5) & 12'hFFF);
    endfunction

    function automatic logic [11:0] charge_of(input int i);
        return 12'((i * 91 + 1234) & 12'hFFF);
    endfunction

    function automatic logic [51:0] rec_of(input int i);
        return {exp_chan[i], exp_ts[i], fine_of(i), charge_of(i)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of triggers and tick; model edges, order and room
    task automatic step(input logic [15:0] tv, input logic tk, input int cap);
        logic [15:0] rise;
        int n;
        @(negedge clk);
        trig = tv;
        tick = tk;
        rise = tv & ~trig_prev;
        n = 0;
        for (int c = 0; c < 16; c++) begin
            if (rise[c]) begin
                if (n < cap) begin
                    exp_chan[exp_wr] = 4'(c);
                    exp_ts[exp_wr] = tick_cnt;
                    exp_wr++;
                end
                n++;
            end
        end
        trig_prev = tv;
        if (tk) tick_cnt = tick_cnt + 24'd1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        trig = '0;
        tick = 1'b0;
        trig_prev = '0;
        tick_cnt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        while (rx_idx != exp_wr && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (200) @(negedge clk);
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Converter model: answers requests with indexed codes
    initial begin
        conv_valid = 1'b0;
        fine = '0;
        charge = '0;
        forever begin
            @(negedge clk);
            if (conv_valid) conv_idx++;
            if (resp_en && conv_ready && (!resp_rand || ($urandom % 3) == 0)) begin
                conv_valid = 1'b1;
                fine = fine_of(conv_idx);
                charge = charge_of(conv_idx);
            end else begin
                conv_valid = 1'b0;
            end
        end
    end

    // Serial receiver: gathers each frame and compares it in arrival order
    initial begin
        logic [51:0] rec;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && ser_frame) begin
                rec = {51'b0, ser_data};
                for (int i = 1; i < 52; i++) begin
                    @(negedge clk);
                    #1;
                    if (!ser_frame) begin
                        checks++;
                        errors++;
                        $display("FAIL R9 frame dropped at bit %0d actual=0 expected=1", i);
                    end
                    rec = {rec[50:0], ser_data};
                end
                @(negedge clk);
                #1;
                check(!ser_frame && !ser_data, "R9 frame end after 52 bits",
                      {62'b0, ser_frame, ser_data}, 64'h0);
                check(rec == rec_of(rx_idx), "R8/R3/R4 record content", 64'(rec),
                      64'(rec_of(rx_idx)));
                rx_idx++;
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (120000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [15:0] tv;
        logic [15:0] rise;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R10: state after reset
        check(!conv_ready, "R10 ready after reset", 64'(conv_ready), 0);
        check(!ser_frame, "R10 frame after reset", 64'(ser_frame), 0);
        check(!ser_data, "R10 data after reset", 64'(ser_data), 0);
        check(!overflow, "R10 overflow after reset", 64'(overflow), 0);
        check(!trig_or, "R1 or idle", 64'(trig_or), 0);

        // Three ticks, then channel 5 held high for five cycles (R2, R3)
        step(16'h0000, 1'b1, 16);
        step(16'h0000, 1'b1, 16);
        step(16'h0000, 1'b1, 16);
        step(16'h0020, 1'b0, 16);
        #1;
        check(trig_or, "R1 or follows trigger", 64'(trig_or), 1);
        step(16'h0020, 1'b0, 16);
        #1;
        check(!conv_ready, "R7 ready one edge after hit", 64'(conv_ready), 0);
        step(16'h0020, 1'b0, 16);
        #1;
        check(conv_ready, "R7 ready two edges after hit", 64'(conv_ready), 1);
        step(16'h0020, 1'b0, 16);
        step(16'h0020, 1'b0, 16);
        #1;
        check(conv_ready, "R7 ready held without valid", 64'(conv_ready), 1);
        step(16'h0000, 1'b0, 16);
        #1;
        check(!trig_or, "R1 or falls with triggers", 64'(trig_or), 0);
        check(!overflow, "R5 no drop with room", 64'(overflow), 0);

        // All channels at once into an empty queue: 0..7 kept, 8..15 lost (R4, R5)
        step(16'hFFFF, 1'b0, 8);
        step(16'h0000, 1'b0, 16);
        #1;
        check(overflow, "R6 overflow one edge after drop", 64'(overflow), 1);

        // Release the converter and time the frame start (R7)
        resp_en = 1'b1;
        @(negedge clk);
        #1;
        check(conv_valid && !ser_frame, "R7 no frame before handshake edge",
              64'(ser_frame), 0);
        @(negedge clk);
        #1;
        check(ser_frame && !conv_ready, "R7 frame one cycle after handshake",
              {62'b0, ser_frame, conv_ready}, 64'h2);
        drain();
        check(rx_idx == 9, "R2/R5 record count after burst", 64'(rx_idx), 9);
        check(overflow, "R6 overflow sticky", 64'(overflow), 1);

        // Reset clears the loss flag (R6, R10)
        do_reset();
        @(negedge clk);
        #1;
        check(!overflow, "R6 overflow cleared by reset", 64'(overflow), 0);
        check(!ser_frame && !conv_ready, "R10 idle after second reset",
              {62'b0, ser_frame, conv_ready}, 0);

        // Random phase: sparse triggers, held levels, ticks, converter latency
        resp_rand = 1'b1;
        for (int k = 0; k < 3000; k++) begin
            if (($urandom % 10) == 0) tv = trig_prev;
            else tv = 16'($urandom & $urandom & $urandom);
            rise = tv & ~trig_prev;
            if ((exp_wr - rx_idx) + $countones(rise) > 8 || exp_wr > 4000) tv = 16'h0;
            step(tv, 1'(($urandom % 4) == 0), 16);
        end
        step(16'h0000, 1'b0, 16);
        drain();
        check(rx_idx == exp_wr, "R2/R4 all random hits delivered", 64'(rx_idx),
              64'(exp_wr));
        check(!overflow, "R5 no loss while room remained", 64'(overflow), 0);

        done = 1'b1;
        report();
        $finish;
    end

endmodule